// File: doc/BRIEF.md
# Privileged Return and System Instruction Unit

This unit sits beside the execute stage of a core with four privilege levels (user, supervisor, hypervisor, machine). It recognises the environment-call, breakpoint, the four level-specific trap-return instructions and the two memory-ordering fences, and computes the result of each in one step. The core supplies the instruction word with a valid strobe, the current privilege level and the current interrupt-enable, previous-enable and previous-privilege fields. It also answers a combinational read of the exception-PC register that the unit addresses.

All effects of an accepted instruction appear together, registered, one clock after it is presented. These effects are the redirect, the new privilege level and status fields with a write strobe, or an exception request with its cause. The core's trap-entry logic consumes the exception request. The fences and the environment call in supervisor or hypervisor mode only retire.

Top module: `sysret_unit`

## Requirements
- R1: The unit recognises exactly these 32-bit words: 0x00000073 (environment call), 0x00100073 (breakpoint), 0x00200073 / 0x10200073 / 0x20200073 / 0x30200073 (return from level U / S / H / M; bits 29:28 carry the level), and any word with bits 6:0 = 0001111 and bits 14:12 = 000 or 001 (fence, instruction fence). Any other word with `i_valid` high produces no redirect, no exception, no retire and no state write, and the held privilege and status outputs keep their values.
- R2: Every output pulse (`o_redirect_valid`, `o_state_we`, `o_exc_valid`, `o_retire`) rises exactly one clock after the cycle in which `i_valid` was high, lasts one cycle, and all of them are low after a cycle with `i_valid` low. An exception and a retire never appear together.
- R3: A return whose level (bits 29:28) differs from `i_prv` raises an exception with cause 2 (illegal instruction), with no redirect and no state write.
- R4: A return addresses the exception-PC register at `o_epc_addr = {2'b00, level, 8'h41}` (0x041, 0x141, 0x241, 0x341), and a legal return redirects to the value read there.
- R5: A legal return from level S, H or M (encoded S = 1, H = 2, M = 3) sets that level's enable to its old previous-enable, sets the previous-enable to 1, moves to the privilege held in that level's previous-privilege field and writes U (0) into that field; all other fields pass through unchanged.
- R6: A legal return from level U (encoded 0), built without user-level interrupts, clears the user enable and user previous-enable and leaves the privilege at U.
- R7: The environment call raises cause 11 in M mode and cause 8 in U mode; in S or H mode it raises nothing and retires.
- R8: The breakpoint instruction raises cause 3 at every privilege level.
- R9: Both fences retire with no redirect, no exception and no state write, whatever their other fields hold.
- R10: After synchronous reset all pulse outputs are low, `o_next_prv` is M (3) and all status outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Instruction word is valid this cycle |
| i_instr | input | 32 | Instruction word |
| i_prv | input | 2 | Current privilege level |
| i_ie | input | 4 | Interrupt enables, bit n for level n |
| i_pie | input | 4 | Previous interrupt enables, bit n for level n |
| i_pp_s | input | 2 | Supervisor previous-privilege field |
| i_pp_h | input | 2 | Hypervisor previous-privilege field |
| i_pp_m | input | 2 | Machine previous-privilege field |
| o_epc_addr | output | 12 | Address of the exception-PC register to read |
| i_epc_rdata | input | XLEN | Data returned for `o_epc_addr` in the same cycle |
| o_redirect_valid | output | 1 | Redirect pulse |
| o_redirect_pc | output | XLEN | Redirect target |
| o_state_we | output | 1 | Privilege and status outputs carry new values |
| o_next_prv | output | 2 | New privilege level |
| o_next_ie | output | 4 | New interrupt enables |
| o_next_pie | output | 4 | New previous interrupt enables |
| o_next_pp_s | output | 2 | New supervisor previous-privilege |
| o_next_pp_h | output | 2 | New hypervisor previous-privilege |
| o_next_pp_m | output | 2 | New machine previous-privilege |
| o_exc_valid | output | 1 | Exception request pulse |
| o_exc_cause | output | 4 | Exception cause code |
| o_retire | output | 1 | Instruction completed without exception |

## Verification
The hardest situation to reach is a legal return whose previous-privilege field points to a level other than the one expected, combined with enable bits that differ from their previous-enable bits. Only then does a swapped or dropped field update show at the ports. The stimulus drives each return at its own level with deliberately asymmetric status patterns, with H and M fields pointing to each other and enables opposite to previous-enables. It then replays the same word at every wrong level. Back-to-back valid cycles alternating legal and illegal returns show that the held status outputs change only on a write strobe.

// File: rtl/sysret_pkg.sv
package sysret_pkg;

  localparam int LVL_W   = 2;
  localparam int NLVL    = 1 << LVL_W;
  localparam int CAUSE_W = 4;
  localparam int CSR_AW  = 12;

  localparam logic [LVL_W-1:0] LVL_U = 2'd0;
  localparam logic [LVL_W-1:0] LVL_S = 2'd1;
  localparam logic [LVL_W-1:0] LVL_H = 2'd2;
  localparam logic [LVL_W-1:0] LVL_M = 2'd3;

  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_BREAK   = 4'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_CALL_U  = 4'd8;
  localparam logic [CAUSE_W-1:0] CAUSE_CALL_M  = 4'd11;

  localparam logic [31:0] WORD_CALL    = 32'h0000_0073;
  localparam logic [31:0] WORD_BREAK   = 32'h0010_0073;
  localparam logic [31:0] WORD_RET_BASE = 32'h0020_0073;
  localparam logic [31:0] RET_LVL_MASK = 32'h3000_0000;
  localparam int          RET_LVL_LSB  = 28;
  localparam logic [6:0]  OPC_FENCE    = 7'b0001111;
  localparam logic [7:0]  EPC_LOW      = 8'h41;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CALL,
    OP_BREAK,
    OP_RET,
    OP_FENCE
  } sys_op_e;

  typedef struct packed {
    logic [NLVL-1:0]  ie;
    logic [NLVL-1:0]  pie;
    logic [LVL_W-1:0] pp_s;
    logic [LVL_W-1:0] pp_h;
    logic [LVL_W-1:0] pp_m;
  } stat_t;

endpackage

// File: rtl/sysret_decode.sv
module sysret_decode
  import sysret_pkg::*;
(
  input  logic [31:0]      word,
  output sys_op_e          op,
  output logic [LVL_W-1:0] ret_lvl
);

  logic is_ret;
  logic is_fence;

  assign is_ret   = (word & ~RET_LVL_MASK) == WORD_RET_BASE;
  assign is_fence = (word[6:0] == OPC_FENCE) &&
                    ((word[14:12] == 3'b000) || (word[14:12] == 3'b001));
  assign ret_lvl  = word[RET_LVL_LSB +: LVL_W];

  always_comb begin
    if (word == WORD_CALL)       op = OP_CALL;
    else if (word == WORD_BREAK) op = OP_BREAK;
    else if (is_ret)             op = OP_RET;
    else if (is_fence)           op = OP_FENCE;
    else                         op = OP_NONE;
  end

endmodule

// File: rtl/sysret_retcalc.sv
module sysret_retcalc
  import sysret_pkg::*;
#(
  parameter bit USER_INT_EN = 1'b0
) (
  input  stat_t            st,
  input  logic [LVL_W-1:0] lvl,
  output stat_t            st_new,
  output logic [LVL_W-1:0] prv_new
);

  logic u_ie_new;
  logic u_pie_new;

  generate
    if (USER_INT_EN) begin : g_uint
      assign u_ie_new  = st.pie[0];
      assign u_pie_new = 1'b1;
    end else begin : g_no_uint
      assign u_ie_new  = 1'b0;
      assign u_pie_new = 1'b0;
    end
  endgenerate

  always_comb begin
    st_new  = st;
    prv_new = LVL_U;
    if (lvl == LVL_U) begin
      st_new.ie[0]  = u_ie_new;
      st_new.pie[0] = u_pie_new;
    end else begin
      st_new.ie[lvl]  = st.pie[lvl];
      st_new.pie[lvl] = 1'b1;
      case (lvl)
        LVL_S: begin
          prv_new     = st.pp_s;
          st_new.pp_s = LVL_U;
        end
        LVL_H: begin
          prv_new     = st.pp_h;
          st_new.pp_h = LVL_U;
        end
        default: begin
          prv_new     = st.pp_m;
          st_new.pp_m = LVL_U;
        end
      endcase
    end
  end

endmodule

// File: rtl/sysret_resolve.sv
module sysret_resolve
  import sysret_pkg::*;
(
  input  sys_op_e            op,
  input  logic [LVL_W-1:0]   ret_lvl,
  input  logic [LVL_W-1:0]   prv,
  output logic               take_exc,
  output logic [CAUSE_W-1:0] cause,
  output logic               commit,
  output logic               retire
);

  always_comb begin
    take_exc = 1'b0;
    cause    = '0;
    commit   = 1'b0;
    retire   = 1'b0;
    case (op)
      OP_CALL: begin
        if (prv == LVL_M) begin
          take_exc = 1'b1;
          cause    = CAUSE_CALL_M;
        end else if (prv == LVL_U) begin
          take_exc = 1'b1;
          cause    = CAUSE_CALL_U;
        end else begin
          retire = 1'b1;
        end
      end
      OP_BREAK: begin
        take_exc = 1'b1;
        cause    = CAUSE_BREAK;
      end
      OP_RET: begin
        if (ret_lvl == prv) begin
          commit = 1'b1;
          retire = 1'b1;
        end else begin
          take_exc = 1'b1;
          cause    = CAUSE_ILLEGAL;
        end
      end
      OP_FENCE: retire = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sysret_unit.sv
module sysret_unit
  import sysret_pkg::*;
#(
  parameter int XLEN        = 64,
  parameter bit USER_INT_EN = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               i_valid,
  input  logic [31:0]        i_instr,
  input  logic [1:0]         i_prv,
  input  logic [3:0]         i_ie,
  input  logic [3:0]         i_pie,
  input  logic [1:0]         i_pp_s,
  input  logic [1:0]         i_pp_h,
  input  logic [1:0]         i_pp_m,
  output logic [11:0]        o_epc_addr,
  input  logic [XLEN-1:0]    i_epc_rdata,
  output logic               o_redirect_valid,
  output logic [XLEN-1:0]    o_redirect_pc,
  output logic               o_state_we,
  output logic [1:0]         o_next_prv,
  output logic [3:0]         o_next_ie,
  output logic [3:0]         o_next_pie,
  output logic [1:0]         o_next_pp_s,
  output logic [1:0]         o_next_pp_h,
  output logic [1:0]         o_next_pp_m,
  output logic               o_exc_valid,
  output logic [3:0]         o_exc_cause,
  output logic               o_retire
);

  localparam int ADDR_PAD = CSR_AW - LVL_W - 8;

  sys_op_e            op;
  logic [LVL_W-1:0]   ret_lvl;
  stat_t              st_in;
  stat_t              st_calc;
  logic [LVL_W-1:0]   prv_calc;
  logic               take_exc;
  logic [CAUSE_W-1:0] cause;
  logic               commit;
  logic               retire;

  stat_t              st_q;
  logic [LVL_W-1:0]   prv_q;

  assign st_in = '{ie: i_ie, pie: i_pie, pp_s: i_pp_s, pp_h: i_pp_h, pp_m: i_pp_m};

  sysret_decode u_decode (
    .word    (i_instr),
    .op      (op),
    .ret_lvl (ret_lvl)
  );

  sysret_retcalc #(.USER_INT_EN(USER_INT_EN)) u_retcalc (
    .st      (st_in),
    .lvl     (ret_lvl),
    .st_new  (st_calc),
    .prv_new (prv_calc)
  );

  sysret_resolve u_resolve (
    .op       (op),
    .ret_lvl  (ret_lvl),
    .prv      (i_prv),
    .take_exc (take_exc),
    .cause    (cause),
    .commit   (commit),
    .retire   (retire)
  );

  assign o_epc_addr = {{ADDR_PAD{1'b0}}, ret_lvl, EPC_LOW};

  always_ff @(posedge clk) begin
    if (rst) begin
      o_redirect_valid <= 1'b0;
      o_redirect_pc    <= '0;
      o_state_we       <= 1'b0;
      o_exc_valid      <= 1'b0;
      o_exc_cause      <= '0;
      o_retire         <= 1'b0;
      prv_q            <= LVL_M;
      st_q             <= '0;
    end else begin
      o_redirect_valid <= i_valid && commit;
      o_state_we       <= i_valid && commit;
      o_exc_valid      <= i_valid && take_exc;
      o_retire         <= i_valid && retire;
      if (i_valid && take_exc) o_exc_cause <= cause;
      if (i_valid && commit) begin
        o_redirect_pc <= i_epc_rdata;
        prv_q         <= prv_calc;
        st_q          <= st_calc;
      end
    end
  end

  assign o_next_prv  = prv_q;
  assign o_next_ie   = st_q.ie;
  assign o_next_pie  = st_q.pie;
  assign o_next_pp_s = st_q.pp_s;
  assign o_next_pp_h = st_q.pp_h;
  assign o_next_pp_m = st_q.pp_m;

endmodule

// File: rtl/sysret_unit_chk.sv
module sysret_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            i_valid,
  input logic [31:0]     i_instr,
  input logic [1:0]      i_prv,
  input logic [XLEN-1:0] i_epc_rdata,
  input logic            o_redirect_valid,
  input logic [XLEN-1:0] o_redirect_pc,
  input logic            o_state_we,
  input logic [3:0]      o_next_pie,
  input logic [1:0]      o_next_pp_m,
  input logic            o_exc_valid,
  input logic [3:0]      o_exc_cause,
  input logic            o_retire
);

  logic ret_word;
  assign ret_word = (i_instr & 32'hCFFF_FFFF) == 32'h0020_0073;

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !i_valid |=> !o_redirect_valid && !o_exc_valid && !o_retire && !o_state_we);

  assert_exc_retire_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(o_exc_valid && o_retire));

  assert_wrong_level_R3: assert property (@(posedge clk) disable iff (rst)
    i_valid && ret_word && (i_instr[29:28] != i_prv)
    |=> o_exc_valid && (o_exc_cause == 4'd2) && !o_state_we && !o_redirect_valid);

  assert_ret_target_R4: assert property (@(posedge clk) disable iff (rst)
    i_valid && ret_word && (i_instr[29:28] == i_prv)
    |=> o_redirect_valid && (o_redirect_pc == $past(i_epc_rdata)));

  assert_mret_fields_R5: assert property (@(posedge clk) disable iff (rst)
    i_valid && (i_instr == 32'h3020_0073) && (i_prv == 2'd3)
    |=> o_state_we && (o_next_pp_m == 2'd0) && o_next_pie[3]);

  assert_break_cause_R8: assert property (@(posedge clk) disable iff (rst)
    i_valid && (i_instr == 32'h0010_0073) |=> o_exc_valid && (o_exc_cause == 4'd3));

endmodule

bind sysret_unit sysret_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .i_valid          (i_valid),
  .i_instr          (i_instr),
  .i_prv            (i_prv),
  .i_epc_rdata      (i_epc_rdata),
  .o_redirect_valid (o_redirect_valid),
  .o_redirect_pc    (o_redirect_pc),
  .o_state_we       (o_state_we),
  .o_next_pie       (o_next_pie),
  .o_next_pp_m      (o_next_pp_m),
  .o_exc_valid      (o_exc_valid),
  .o_exc_cause      (o_exc_cause),
  .o_retire         (o_retire)
);

// File: tb/sysret_unit_bench.sv
module sysret_unit_bench;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            i_valid = 1'b0;
  logic [31:0]     i_instr = '0;
  logic [1:0]      i_prv = 2'd3;
  logic [3:0]      i_ie = '0;
  logic [3:0]      i_pie = '0;
  logic [1:0]      i_pp_s = '0, i_pp_h = '0, i_pp_m = '0;
  logic [11:0]     o_epc_addr;
  logic [XLEN-1:0] i_epc_rdata;
  logic            o_redirect_valid, o_state_we, o_exc_valid, o_retire;
  logic [XLEN-1:0] o_redirect_pc;
  logic [1:0]      o_next_prv, o_next_pp_s, o_next_pp_h, o_next_pp_m;
  logic [3:0]      o_next_ie, o_next_pie, o_exc_cause;

  always #5 clk = ~clk;

  sysret_unit #(.XLEN(XLEN)) u_sysret_unit (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_instr(i_instr), .i_prv(i_prv),
    .i_ie(i_ie), .i_pie(i_pie), .i_pp_s(i_pp_s), .i_pp_h(i_pp_h), .i_pp_m(i_pp_m),
    .o_epc_addr(o_epc_addr), .i_epc_rdata(i_epc_rdata),
    .o_redirect_valid(o_redirect_valid), .o_redirect_pc(o_redirect_pc),
    .o_state_we(o_state_we), .o_next_prv(o_next_prv), .o_next_ie(o_next_ie),
    .o_next_pie(o_next_pie), .o_next_pp_s(o_next_pp_s), .o_next_pp_h(o_next_pp_h),
    .o_next_pp_m(o_next_pp_m), .o_exc_valid(o_exc_valid), .o_exc_cause(o_exc_cause),
    .o_retire(o_retire)
  );

  logic [XLEN-1:0] epc_regs [4];
  initial begin
    epc_regs[0] = 64'h0000_0000_1000_0100;
    epc_regs[1] = 64'h0000_0000_2000_0200;
    epc_regs[2] = 64'h0000_0000_3000_0300;
    epc_regs[3] = 64'h8000_0000_4000_0400;
  end
  always_comb begin
    if (o_epc_addr[7:0] == 8'h41 && o_epc_addr[11:10] == 2'b00)
      i_epc_rdata = epc_regs[o_epc_addr[9:8]];
    else
      i_epc_rdata = 64'hDEAD_BEEF_DEAD_BEEF;
  end

  typedef struct {
    logic            rv;
    logic [XLEN-1:0] pc;
    logic            we;
    logic [1:0]      prv;
    logic [3:0]      ie, pie;
    logic [1:0]      pps, pph, ppm;
    logic            ev;
    logic [3:0]      cause;
    logic            ret;
    string           tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;

  logic [1:0] h_prv = 2'd3;
  logic [3:0] h_ie = '0, h_pie = '0;
  logic [1:0] h_pps = '0, h_pph = '0, h_ppm = '0;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [1:0] p,
                       input logic [3:0] ie, input logic [3:0] pie,
                       input logic [1:0] pps, input logic [1:0] pph,
                       input logic [1:0] ppm, input string tag);
    exp_t e;
    logic [1:0] lv;
    @(negedge clk);
    i_valid = 1'b1; i_instr = w; i_prv = p;
    i_ie = ie; i_pie = pie; i_pp_s = pps; i_pp_h = pph; i_pp_m = ppm;
    e.rv = 0; e.pc = '0; e.we = 0; e.ev = 0; e.cause = 0; e.ret = 0; e.tag = tag;
    lv = w[29:28];
    if (w == 32'h0000_0073) begin
      if (p == 2'd3) begin e.ev = 1; e.cause = 4'd11; end
      else if (p == 2'd0) begin e.ev = 1; e.cause = 4'd8; end
      else e.ret = 1;
    end else if (w == 32'h0010_0073) begin
      e.ev = 1; e.cause = 4'd3;
    end else if ((w & 32'hCFFF_FFFF) == 32'h0020_0073) begin
      if (lv != p) begin
        e.ev = 1; e.cause = 4'd2;
      end else begin
        e.rv = 1; e.we = 1; e.ret = 1; e.pc = epc_regs[lv];
        h_ie = ie; h_pie = pie; h_pps = pps; h_pph = pph; h_ppm = ppm;
        if (lv == 2'd0) begin
          h_ie[0] = 0; h_pie[0] = 0; h_prv = 2'd0;
        end else begin
          h_ie[lv] = pie[lv]; h_pie[lv] = 1'b1;
          case (lv)
            2'd1: begin h_prv = pps; h_pps = 2'd0; end
            2'd2: begin h_prv = pph; h_pph = 2'd0; end
            default: begin h_prv = ppm; h_ppm = 2'd0; end
          endcase
        end
      end
    end else if (w[6:0] == 7'b0001111 && (w[14:12] == 3'b000 || w[14:12] == 3'b001)) begin
      e.ret = 1;
    end
    e.prv = h_prv; e.ie = h_ie; e.pie = h_pie; e.pps = h_pps; e.pph = h_pph; e.ppm = h_ppm;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    i_valid = 1'b0;
    i_instr = 32'h0000_0073;
    e.rv = 0; e.pc = '0; e.we = 0; e.ev = 0; e.cause = 0; e.ret = 0; e.tag = tag;
    e.prv = h_prv; e.ie = h_ie; e.pie = h_pie; e.pps = h_pps; e.pph = h_pph; e.ppm = h_ppm;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(o_redirect_valid == e.rv, e.tag, "redirect_valid", 64'(o_redirect_valid), 64'(e.rv));
        if (e.rv) chk(o_redirect_pc == e.pc, e.tag, "redirect_pc", o_redirect_pc, e.pc);
        chk(o_state_we == e.we, e.tag, "state_we", 64'(o_state_we), 64'(e.we));
        chk(o_exc_valid == e.ev, e.tag, "exc_valid", 64'(o_exc_valid), 64'(e.ev));
        if (e.ev) chk(o_exc_cause == e.cause, e.tag, "exc_cause", 64'(o_exc_cause), 64'(e.cause));
        chk(o_retire == e.ret, e.tag, "retire", 64'(o_retire), 64'(e.ret));
        chk({o_next_prv, o_next_ie, o_next_pie, o_next_pp_s, o_next_pp_h, o_next_pp_m} ==
            {e.prv, e.ie, e.pie, e.pps, e.pph, e.ppm}, e.tag, "prv/status",
            64'({o_next_prv, o_next_ie, o_next_pie, o_next_pp_s, o_next_pp_h, o_next_pp_m}),
            64'({e.prv, e.ie, e.pie, e.pps, e.pph, e.ppm}));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10 reset state
    chk(!o_redirect_valid && !o_state_we && !o_exc_valid && !o_retire, "R10", "pulses",
        64'({o_redirect_valid, o_state_we, o_exc_valid, o_retire}), 64'h0);
    chk(o_next_prv == 2'd3, "R10", "next_prv", 64'(o_next_prv), 64'd3);
    chk({o_next_ie, o_next_pie, o_next_pp_s, o_next_pp_h, o_next_pp_m} == '0, "R10", "status",
        64'({o_next_ie, o_next_pie, o_next_pp_s, o_next_pp_h, o_next_pp_m}), 64'h0);
    // R4 address presented combinationally
    i_instr = 32'h2020_0073; #1;
    chk(o_epc_addr == 12'h241, "R4", "epc_addr", 64'(o_epc_addr), 64'h241);
    i_instr = 32'h1020_0073; #1;
    chk(o_epc_addr == 12'h141, "R4", "epc_addr", 64'(o_epc_addr), 64'h141);

    // R5 machine return, pp_m = S
    drive(32'h3020_0073, 2'd3, 4'b1010, 4'b0101, 2'd3, 2'd1, 2'd1, "R5 R4 mret");
    // R3 machine return at S
    drive(32'h3020_0073, 2'd1, 4'b1111, 4'b0000, 2'd1, 2'd3, 2'd2, "R3 mret@S");
    // R5 supervisor return to U
    drive(32'h1020_0073, 2'd1, 4'b0010, 4'b1110, 2'd0, 2'd3, 2'd2, "R5 sret");
    // R5 hypervisor return to M
    drive(32'h2020_0073, 2'd2, 4'b0100, 4'b1011, 2'd1, 2'd3, 2'd2, "R5 hret");
    idle("R2 idle");
    // R6 user return
    drive(32'h0020_0073, 2'd0, 4'b1011, 4'b0101, 2'd1, 2'd2, 2'd3, "R6 uret");
    // R3 every wrong level
    for (int w = 0; w < 4; w++)
      for (int p = 0; p < 4; p++)
        if (w != p)
          drive(32'h0020_0073 | (32'(w) << 28), 2'(p), 4'hF, 4'h0, 2'd1, 2'd2, 2'd3, "R3 wrong level");
    // R5 M return into H, then H return into M, back to back
    drive(32'h3020_0073, 2'd3, 4'b0111, 4'b1000, 2'd1, 2'd3, 2'd2, "R5 mret->H");
    drive(32'h2020_0073, 2'd2, 4'b1011, 4'b0000, 2'd0, 2'd3, 2'd0, "R5 hret->M");
    // R7 environment call at all levels
    for (int p = 0; p < 4; p++)
      drive(32'h0000_0073, 2'(p), 4'h3, 4'hC, 2'd0, 2'd0, 2'd0, "R7 ecall");
    // R8 breakpoint at all levels
    for (int p = 0; p < 4; p++)
      drive(32'h0010_0073, 2'(p), 4'h0, 4'h0, 2'd0, 2'd0, 2'd0, "R8 ebreak");
    // R9 fences with assorted fields
    drive(32'h0FF0_000F, 2'd0, 4'h0, 4'h0, 2'd0, 2'd0, 2'd0, "R9 fence");
    drive(32'h0000_100F, 2'd3, 4'h0, 4'h0, 2'd0, 2'd0, 2'd0, "R9 fence.i");
    drive(32'hFFFF_908F, 2'd1, 4'h0, 4'h0, 2'd0, 2'd0, 2'd0, "R9 fence.i fields");
    // R1 unrecognised words ignored
    drive(32'h0000_200F, 2'd3, 4'hF, 4'hF, 2'd3, 2'd3, 2'd3, "R1 fence funct3=2");
    drive(32'h3420_2373, 2'd3, 4'hF, 4'hF, 2'd3, 2'd3, 2'd3, "R1 csr read");
    drive(32'h1050_0073, 2'd1, 4'hF, 4'hF, 2'd3, 2'd3, 2'd3, "R1 wfi");
    drive(32'h7020_0073, 2'd3, 4'hF, 4'hF, 2'd3, 2'd3, 2'd3, "R1 bit30 set");
    drive(32'h0000_0013, 2'd0, 4'hF, 4'hF, 2'd3, 2'd3, 2'd3, "R1 nop");
    idle("R2 idle end");
    idle("R2 idle end");
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule